// File: doc/BRIEF.md
# Line Buffer Drain-and-Clear Sequencer

This block is the read-out half of a small pixel line buffer. When a requester raises chip select with the read/write line set to read, the block starts a sweep and runs it to the end without further help. It visits every location of the attached memory in ascending address order. At each location it first presents the stored pixel on its output, with an output-enable strobe. It then overwrites that location with a background colour. The whole buffer is emptied and reset to the background in one pass.

Each location takes two clock cycles. A one-bit phase register chooses between the output cycle and the clear cycle. An address counter advances once per location, and a terminal-count flag from the counter tells the controller when to finish. A busy flag is high for the whole sweep. The requester keeps its request lines steady until busy falls. The memory is outside the block: the block drives its address, write strobe and write data, and receives its asynchronous read data. The pad drivers are modelled as a data output plus an output-enable.

Top module: `line_drain_clear`

## Requirements
- R1: While reset is active and right after it, busy_o, pix_oe_o and mem_we_o are 0 and pix_o is 0.
- R2: A clock edge with the block idle, cs_i=1 and rw_i=0 (0 means read) starts a sweep. busy_o is 1 from that edge for exactly 2*DEPTH cycles and then returns to 0.
- R3: In the first cycle of each location, mem_addr_o gives the location, pix_oe_o=1, pix_o equals mem_rdata_i, and mem_we_o=0.
- R4: In the second cycle of each location, mem_we_o=1, mem_addr_o is unchanged from the first cycle, and mem_wdata_o carries the background colour.
- R5: A sweep visits addresses 0 through DEPTH-1 exactly once each, in ascending order, starting from 0.
- R6: bg_i is captured on the edge that starts the sweep. Changes to bg_i later in the sweep do not alter the colour written.
- R7: Requests of either kind arriving while busy_o=1 are ignored, and the sweep goes on unchanged. A write request (cs_i=1, rw_i=1) from idle starts nothing.
- R8: Outside the first cycle of a location, pix_oe_o=0 and pix_o=0.
- R9: After busy_o falls, a new read request starts a fresh sweep from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select |
| rw_i | input | 1 | 1 = write request, 0 = read (sweep) request |
| bg_i | input | 8 | Background colour for the next sweep |
| mem_rdata_i | input | 8 | Asynchronous read data from the buffer memory |
| mem_addr_o | output | 4 | Memory address from the sweep counter |
| mem_we_o | output | 1 | Memory write strobe for the clear cycle |
| mem_wdata_o | output | 8 | Background colour written during the clear cycle |
| pix_o | output | 8 | Pixel output, zero when not enabled |
| pix_oe_o | output | 1 | Output enable for the pixel pads |
| busy_o | output | 1 | High for the whole sweep |

## Verification
The assertions assume that the memory returns, in the same cycle and without registering it, the word at the address the block drives. They also assume that the requester holds reset low for at least one edge before the first request. The bench's memory model reads asynchronously and only takes writes when mem_we_o is high. The bench drives cs_i, rw_i and bg_i on falling edges only. On purpose, it raises read and write requests and moves bg_i in the middle of a sweep, which is allowed input even though those requests must be ignored.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    localparam int PIX_W = 8;

    localparam logic RW_READ  = 1'b0;
    localparam logic RW_WRITE = 1'b1;

    typedef enum logic {
        PH_SHOW  = 1'b0,
        PH_CLEAR = 1'b1
    } phase_e;

    typedef struct packed {
        logic   busy;
        phase_e phase;
    } ctrl_t;

endpackage

// File: rtl/ldc_addr_counter.sv
module ldc_addr_counter #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    output logic [ADDR_W-1:0] cnt_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = (cnt_q == LAST_ADDR) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == LAST_ADDR);

    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0) else $error("counter not cleared"); // R9

    AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !last_o) |=> cnt_o == $past(cnt_o) + 1'b1) else $error("counter skipped"); // R5

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(cnt_o)) else $error("counter moved while idle"); // R4

endmodule

// File: rtl/ldc_phase_ctrl.sv
module ldc_phase_ctrl #(
    parameter int DATA_W = ldc_pkg::PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              rw_i,
    input  logic [DATA_W-1:0] bg_i,
    input  logic              last_i,
    output logic              start_o,
    output logic              step_o,
    output logic              busy_o,
    output ldc_pkg::phase_e   phase_o,
    output logic [DATA_W-1:0] bg_o
);

    import ldc_pkg::*;

    ctrl_t             st_d, st_q;
    logic [DATA_W-1:0] bg_d, bg_q;
    logic              start;

    assign start = !st_q.busy && cs_i && (rw_i == RW_READ);

    always_comb begin
        st_d = st_q;
        bg_d = bg_q;
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.phase = PH_SHOW;
            bg_d       = bg_i;
        end else if (st_q.busy) begin
            if (st_q.phase == PH_SHOW) begin
                st_d.phase = PH_CLEAR;
            end else begin
                st_d.phase = PH_SHOW;
                if (last_i) begin
                    st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, phase: PH_SHOW};
            bg_q <= '0;
        end else begin
            st_q <= st_d;
            bg_q <= bg_d;
        end
    end

    assign start_o = start;
    assign step_o  = st_q.busy && (st_q.phase == PH_CLEAR);
    assign busy_o  = st_q.busy;
    assign phase_o = st_q.phase;
    assign bg_o    = bg_q;

    AST_SWEEP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cs_i && rw_i == RW_READ) |=> (busy_o && phase_o == PH_SHOW)) else $error("no start"); // R2

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(cs_i && rw_i == RW_READ)) |=> !busy_o) else $error("spurious start"); // R7

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && phase_o == PH_SHOW) |=> (busy_o && phase_o == PH_CLEAR)) else $error("phase stuck"); // R3

    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && phase_o == PH_CLEAR && last_i) |=> !busy_o) else $error("busy overstayed"); // R2

    AST_BG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(bg_o)) else $error("background moved"); // R6

endmodule

// File: rtl/ldc_out_stage.sv
module ldc_out_stage #(
    parameter int DATA_W = ldc_pkg::PIX_W
) (
    input  logic              busy_i,
    input  ldc_pkg::phase_e   phase_i,
    input  logic [DATA_W-1:0] bg_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] pix_o,
    output logic              oe_o,
    output logic              we_o,
    output logic [DATA_W-1:0] wdata_o
);

    import ldc_pkg::*;

    always_comb begin
        oe_o    = busy_i && (phase_i == PH_SHOW);
        we_o    = busy_i && (phase_i == PH_CLEAR);
        pix_o   = oe_o ? rdata_i : '0;
        wdata_o = we_o ? bg_i : '0;
    end

endmodule

// File: rtl/line_drain_clear.sv
module line_drain_clear #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = ldc_pkg::PIX_W,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              rw_i,
    input  logic [DATA_W-1:0] bg_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W-1:0] pix_o,
    output logic              pix_oe_o,
    output logic              busy_o
);

    ldc_pkg::phase_e   phase;
    logic              start, step, last;
    logic [DATA_W-1:0] bg_held;

    ldc_phase_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs_i),
        .rw_i    (rw_i),
        .bg_i    (bg_i),
        .last_i  (last),
        .start_o (start),
        .step_o  (step),
        .busy_o  (busy_o),
        .phase_o (phase),
        .bg_o    (bg_held)
    );

    ldc_addr_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start),
        .en_i   (step),
        .cnt_o  (mem_addr_o),
        .last_o (last)
    );

    ldc_out_stage #(.DATA_W(DATA_W)) u_out (
        .busy_i  (busy_o),
        .phase_i (phase),
        .bg_i    (bg_held),
        .rdata_i (mem_rdata_i),
        .pix_o   (pix_o),
        .oe_o    (pix_oe_o),
        .we_o    (mem_we_o),
        .wdata_o (mem_wdata_o)
    );

    AST_CLEAR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($stable(mem_addr_o) && $past(pix_oe_o))) else $error("clear moved address"); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!pix_oe_o && !mem_we_o && pix_o == '0)) else $error("output while idle"); // R8

    AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> mem_addr_o == '0) else $error("counter not wrapped"); // R5

endmodule

// File: tb/test_line_drain_clear.sv
module test_line_drain_clear;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int DW         = 8;
    localparam int AW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0;
    logic          rw = 1'b0;
    logic [DW-1:0] bg = '0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] pix;
    logic          pix_oe;
    logic          busy;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0]      mem [DEPTH];
    logic [AW+DW-1:0]   exp_q [$];
    logic [DW-1:0]      exp_bg;
    logic [AW-1:0]      last_shown;
    logic               mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_drain_clear #(.DEPTH(DEPTH), .DATA_W(DW)) i_line_drain_clear (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_i        (cs),
        .rw_i        (rw),
        .bg_i        (bg),
        .mem_rdata_i (mem_rdata),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .pix_o       (pix),
        .pix_oe_o    (pix_oe),
        .busy_o      (busy)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected reads, checks clears and idle outputs
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (pix_oe) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 extra read", int'(mem_addr), -1);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check(mem_addr == e[AW+DW-1:DW], "R5 address order", int'(mem_addr), int'(e[AW+DW-1:DW]));
                    check(pix == e[DW-1:0], "R3 pixel data", int'(pix), int'(e[DW-1:0]));
                    check(!mem_we, "R3 no write in show cycle", int'(mem_we), 0);
                end
                last_shown = mem_addr;
            end else begin
                check(pix == '0, "R8 pixel zero", int'(pix), 0);
                if (mem_we) begin
                    check(mem_addr == last_shown, "R4 same address", int'(mem_addr), int'(last_shown));
                    check(mem_wdata == exp_bg, "R4 R6 background", int'(mem_wdata), int'(exp_bg));
                end
            end
        end
    end

    task automatic load(input int mult, input int add);
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * mult + add);
    endtask

    // driver: queue expected reads, request, disturb, count busy
    task automatic sweep(input logic [DW-1:0] colour, input bit disturb, input string req);
        int busy_cnt;
        for (int i = 0; i < DEPTH; i++) exp_q.push_back({AW'(i), mem[i]});
        exp_bg = colour;
        @(negedge clk);
        cs = 1'b1; rw = 1'b0; bg = colour;
        @(negedge clk);
        busy_cnt = 0;
        cs = 1'b0;
        while (busy && busy_cnt < 4 * DEPTH) begin
            busy_cnt++;
            if (disturb && busy_cnt == 5) begin cs = 1'b1; rw = 1'b0; bg = ~colour; end
            if (disturb && busy_cnt == 9) begin cs = 1'b1; rw = 1'b1; end
            if (disturb && busy_cnt == 13) begin cs = 1'b0; end
            @(negedge clk);
        end
        cs = 1'b0;
        check(busy_cnt == 2 * DEPTH, {req, " busy length"}, busy_cnt, 2 * DEPTH);
        check(exp_q.size() == 0, "R5 all locations read", exp_q.size(), 0);
        for (int i = 0; i < DEPTH; i++)
            check(mem[i] == colour, "R4 cleared to background", int'(mem[i]), int'(colour));
    endtask

    initial begin
        load(1, 0);
        repeat (3) @(negedge clk);
        // R1
        check(!busy && !pix_oe && !mem_we && pix == '0, "R1 reset state",
              int'({busy, pix_oe, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !pix_oe && !mem_we, "R1 after reset", int'({busy, pix_oe, mem_we}), 0);
        mon_on = 1'b1;

        // R7: write request from idle starts nothing
        cs = 1'b1; rw = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(!busy && !pix_oe && !mem_we, "R7 idle write ignored", int'({busy, pix_oe, mem_we}), 0);
        end
        cs = 1'b0;

        // R2 R3 R4 R5: plain sweep
        load(17, 3);
        sweep(8'h5A, 1'b0, "R2");

        // R6 R7: disturbed sweep, bg changes and requests mid-sweep
        load(29, 200);
        sweep(8'hC3, 1'b1, "R7");

        // R9: back-to-back sweep restarts at address 0
        load(7, 1);
        sweep(8'h00, 1'b0, "R9");
        @(negedge clk);
        check(!busy && !pix_oe, "R8 idle after sweep", int'({busy, pix_oe}), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule